// File: doc/BRIEF.md
# Banked Framebuffer Access Unit

This unit sits between a host that sees video memory through a 64 KiB byte window and a larger video memory built from a synchronous single-port byte RAM. While any packed-pixel mode (8, 15 or 16 bits per pixel) is enabled, the unit turns each host byte access into one or more memory cycles. The address is offset by a bank register. Reads and writes each have their own bank.

Two addressing schemes are supported. In linear (chained) mode a host byte maps to exactly one memory byte. In planar mode a host byte stands for four interleaved plane bytes. A write stores the host byte into every plane whose map-mask bit is set. A read returns the bitwise OR of the enabled planes. Planar cycles are issued one at a time, in ascending plane order, and planes that are masked off take no cycle. While all packed modes are disabled, every access is handed unchanged to a legacy port and that port's read data is returned to the host.

Top module: `fbx_bank_xlate`

## Requirements
- R1: With all three bits of `pix_mode_en` low, an accepted host access appears on the legacy port in the same cycle with the same direction, offset and data, no memory cycle is issued, and a legacy read response is returned on `host_rdata`/`host_rvalid`.
- R2: With a packed mode enabled, a host access whose offset bit 16 is set issues no memory cycle. A write is dropped. A read returns 0x00 with `host_rvalid` one cycle after acceptance.
- R3: In linear mode (`linear_sel` = 1) an access issues exactly one memory cycle at address offset[15:0] + bank × 0x10000.
- R4: In planar mode (`linear_sel` = 0) the cycle for plane i (mask bit i) uses address offset[15:0] × 4 + i + bank × 0x10000. Enabled planes are visited from plane 0 upwards.
- R5: A planar write stores the host byte into every plane whose `plane_mask` bit is 1 and leaves the bytes of masked planes unchanged.
- R6: A planar read returns the bitwise OR of the bytes of every enabled plane.
- R7: Reads are offset by `rd_bank` and writes by `wr_bank`. Both are sampled when the access is accepted.
- R8: An access issues exactly one memory cycle per enabled plane (one in linear mode), with no idle cycle for masked planes, and `host_busy` is high whenever a memory cycle is issued.
- R9: Memory addresses wrap modulo 2^AW (default 2^20 bytes).
- R10: After reset the unit is idle (`host_busy`, `host_rvalid`, `mem_en` low). Each read yields a single one-cycle `host_rvalid` pulse, which follows the last memory cycle by two clock edges.
- R11: A planar read with `plane_mask` = 0 returns 0x00 one cycle after acceptance without any memory cycle. A planar write with a zero mask changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_mode_en | input | 3 | Packed-pixel enables (8, 15, 16 bpp); any bit set selects banked translation |
| linear_sel | input | 1 | 1 = linear addressing, 0 = planar addressing |
| rd_bank | input | 4 | Bank applied to reads |
| wr_bank | input | 4 | Bank applied to writes |
| plane_mask | input | 4 | Planar enable per plane, bit i = plane i |
| host_req | input | 1 | Access request, accepted when `host_busy` is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 17 | Window offset; bit 16 marks an out-of-window access |
| host_wdata | input | 8 | Write byte |
| host_busy | output | 1 | Unit is working on an access |
| host_rvalid | output | 1 | Read data valid pulse |
| host_rdata | output | 8 | Read byte |
| legacy_req | output | 1 | Forwarded request when no packed mode is on |
| legacy_we | output | 1 | Forwarded direction |
| legacy_ofs | output | 17 | Forwarded offset |
| legacy_wdata | output | 8 | Forwarded write byte |
| legacy_rvalid | input | 1 | Legacy read data valid |
| legacy_rdata | input | 8 | Legacy read byte |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid the cycle after a read cycle |

## Verification
The assertions take for granted that the memory returns read data exactly one cycle after a read cycle, and that a legacy read response never lands in the same cycle as a banked read completion. They also assume the host raises `host_req` only when it means to start a new access. The stimulus changes modes, banks and masks only while the unit is idle. It holds each request for a single accepted cycle, and it waits for every outstanding read, legacy ones included, before it starts the next access. The bench's memory and legacy models answer with fixed one-cycle latency.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
    localparam int FBX_PLANES = 4;
    localparam int FBX_IDX_W  = $clog2(FBX_PLANES);
    localparam int FBX_DW     = 8;
    localparam int FBX_WIN_W  = 16;
    localparam int FBX_BANK_W = 4;
    localparam int FBX_MODES  = 3;

    // Registered control of one in-flight access plus read return.
    typedef struct packed {
        logic                  active;
        logic                  we;
        logic                  planar;
        logic [FBX_PLANES-1:0] left;
        logic [FBX_WIN_W-1:0]  ofs;
        logic [FBX_BANK_W-1:0] bank;
        logic [FBX_DW-1:0]     wdata;
        logic [FBX_DW-1:0]     acc;
        logic                  pend_rd;
        logic                  pend_last;
        logic                  rvalid;
        logic [FBX_DW-1:0]     rdata;
    } fbx_ctl_t;
endpackage

// File: rtl/fbx_plane_pick.sv
module fbx_plane_pick #(
    parameter int P  = 4,
    parameter int IW = 2
) (
    input  logic [P-1:0]  left,
    output logic [P-1:0]  hot,
    output logic [IW-1:0] idx
);
    // Lowest remaining plane wins; masked planes are simply skipped.
    for (genvar g = 0; g < P; g++) begin : g_pick
        if (g == 0) begin : g_first
            assign hot[g] = left[g];
        end else begin : g_rest
            assign hot[g] = left[g] & ~(|left[g-1:0]);
        end
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < P; i++) begin
            if (hot[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/fbx_addr_gen.sv
module fbx_addr_gen #(
    parameter int AW     = 20,
    parameter int BANK_W = 4,
    parameter int WIN_W  = 16,
    parameter int IW     = 2
) (
    input  logic              planar,
    input  logic [BANK_W-1:0] bank,
    input  logic [WIN_W-1:0]  ofs,
    input  logic [IW-1:0]     idx,
    output logic [AW-1:0]     addr
);
    localparam int SUM_W  = BANK_W + WIN_W + IW + 1;
    localparam int FULL_W = (AW > SUM_W) ? AW : SUM_W;

    logic [FULL_W-1:0] base;
    logic [FULL_W-1:0] span;
    logic [FULL_W-1:0] full;

    always_comb begin
        base = FULL_W'({bank, {WIN_W{1'b0}}});
        if (planar) span = FULL_W'({ofs, {IW{1'b0}}}) + FULL_W'(idx);
        else        span = FULL_W'(ofs);
        full = base + span;
    end

    // Truncation gives modulo-2^AW wrap.
    assign addr = full[AW-1:0];
endmodule

// File: rtl/fbx_bank_xlate.sv
module fbx_bank_xlate
    import fbx_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FBX_MODES-1:0]  pix_mode_en,
    input  logic                  linear_sel,
    input  logic [FBX_BANK_W-1:0] rd_bank,
    input  logic [FBX_BANK_W-1:0] wr_bank,
    input  logic [FBX_PLANES-1:0] plane_mask,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [FBX_WIN_W:0]    host_ofs,
    input  logic [FBX_DW-1:0]     host_wdata,
    output logic                  host_busy,
    output logic                  host_rvalid,
    output logic [FBX_DW-1:0]     host_rdata,
    output logic                  legacy_req,
    output logic                  legacy_we,
    output logic [FBX_WIN_W:0]    legacy_ofs,
    output logic [FBX_DW-1:0]     legacy_wdata,
    input  logic                  legacy_rvalid,
    input  logic [FBX_DW-1:0]     legacy_rdata,
    output logic                  mem_en,
    output logic                  mem_we,
    output logic [AW-1:0]         mem_addr,
    output logic [FBX_DW-1:0]     mem_wdata,
    input  logic [FBX_DW-1:0]     mem_rdata
);
    localparam int P  = FBX_PLANES;
    localparam int IW = FBX_IDX_W;

    fbx_ctl_t ctl_d, ctl_q;

    logic          banked;
    logic          accept;
    logic          drop;
    logic [P-1:0]  pick_hot;
    logic [IW-1:0] pick_idx;

    assign banked    = |pix_mode_en;
    assign host_busy = ctl_q.active | ctl_q.pend_rd;
    assign accept    = host_req & banked & ~host_busy;
    assign drop      = host_ofs[FBX_WIN_W] | (~linear_sel & ~(|plane_mask));

    fbx_plane_pick #(.P(P), .IW(IW)) u_pick (
        .left (ctl_q.left),
        .hot  (pick_hot),
        .idx  (pick_idx)
    );

    fbx_addr_gen #(.AW(AW), .BANK_W(FBX_BANK_W), .WIN_W(FBX_WIN_W), .IW(IW)) u_addr (
        .planar (ctl_q.planar),
        .bank   (ctl_q.bank),
        .ofs    (ctl_q.ofs),
        .idx    (pick_idx),
        .addr   (mem_addr)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rvalid    = 1'b0;
        ctl_d.pend_rd   = 1'b0;
        ctl_d.pend_last = 1'b0;
        mem_en          = 1'b0;
        mem_we          = 1'b0;

        // Collect read data of the cycle issued one clock earlier.
        if (ctl_q.pend_rd) begin
            ctl_d.acc = ctl_q.acc | mem_rdata;
            if (ctl_q.pend_last) begin
                ctl_d.rvalid = 1'b1;
                ctl_d.rdata  = ctl_q.acc | mem_rdata;
            end
        end

        if (ctl_q.active) begin
            mem_en     = 1'b1;
            mem_we     = ctl_q.we;
            ctl_d.left = ctl_q.left & ~pick_hot;
            if (!ctl_q.we) begin
                ctl_d.pend_rd   = 1'b1;
                ctl_d.pend_last = (ctl_d.left == '0);
            end
            if (ctl_d.left == '0) ctl_d.active = 1'b0;
        end else if (accept) begin
            if (drop) begin
                if (!host_we) begin
                    ctl_d.rvalid = 1'b1;
                    ctl_d.rdata  = '0;
                end
            end else begin
                ctl_d.active = 1'b1;
                ctl_d.we     = host_we;
                ctl_d.planar = ~linear_sel;
                ctl_d.left   = linear_sel ? P'(1) : plane_mask;
                ctl_d.ofs    = host_ofs[FBX_WIN_W-1:0];
                ctl_d.bank   = host_we ? wr_bank : rd_bank;
                ctl_d.wdata  = host_wdata;
                ctl_d.acc    = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mem_wdata    = ctl_q.wdata;
    assign legacy_req   = host_req & ~banked & ~host_busy;
    assign legacy_we    = host_we;
    assign legacy_ofs   = host_ofs;
    assign legacy_wdata = host_wdata;
    assign host_rvalid  = ctl_q.rvalid | legacy_rvalid;
    assign host_rdata   = ctl_q.rvalid ? ctl_q.rdata : legacy_rdata;
endmodule

// File: rtl/fbx_bank_xlate_chk.sv
module fbx_bank_xlate_chk #(
    parameter int WIN_W = 16,
    parameter int MW    = 3,
    parameter int PW    = 4,
    parameter int DW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [MW-1:0] pix_mode_en,
    input logic          linear_sel,
    input logic [PW-1:0] plane_mask,
    input logic          host_req,
    input logic          host_we,
    input logic [WIN_W:0] host_ofs,
    input logic          host_busy,
    input logic          host_rvalid,
    input logic [DW-1:0] host_rdata,
    input logic          legacy_req,
    input logic          legacy_rvalid,
    input logic          mem_en,
    input logic          mem_we,
    input logic [DW-1:0] mem_wdata
);
    logic take;
    assign take = host_req && !host_busy && (|pix_mode_en);

    // R2
    drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && host_we && host_ofs[WIN_W] |=> !mem_en);

    // R2
    drop_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !host_we && host_ofs[WIN_W] |=> host_rvalid && host_rdata == '0);

    // R11
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !host_we && !linear_sel && plane_mask == '0
        |=> host_rvalid && host_rdata == '0 && !mem_en);

    // R1
    legacy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_req |=> !mem_en);

    // R8
    mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> host_busy);

    // R5
    burst_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && mem_we && $past(mem_en && mem_we) |-> $stable(mem_wdata));

    // R10
    read_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && !mem_we |=> host_busy && !(host_rvalid && !legacy_rvalid));
endmodule

bind fbx_bank_xlate fbx_bank_xlate_chk #(
    .WIN_W (fbx_pkg::FBX_WIN_W),
    .MW    (fbx_pkg::FBX_MODES),
    .PW    (fbx_pkg::FBX_PLANES),
    .DW    (fbx_pkg::FBX_DW)
) u_chk (.*);

// File: tb/fbx_bank_xlate_bench.sv
`timescale 1ns/1ps
module fbx_bank_xlate_bench;
    localparam int AW = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pix_mode_en = '0;
    logic        linear_sel = 1'b1;
    logic [3:0]  rd_bank = '0, wr_bank = '0, plane_mask = '0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [16:0] host_ofs = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_busy, host_rvalid;
    logic [7:0]  host_rdata;
    logic        legacy_req, legacy_we;
    logic [16:0] legacy_ofs;
    logic [7:0]  legacy_wdata;
    logic        legacy_rvalid = 1'b0;
    logic [7:0]  legacy_rdata = '0;
    logic        mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    always #2 clk = ~clk;

    fbx_bank_xlate #(.AW(AW)) u_fbx_bank_xlate (.*);

    int checks = 0, fails = 0;
    int memcnt = 0, legcnt = 0;
    logic [7:0] vmem [int];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    // Synchronous byte RAM and legacy responder models.
    always @(posedge clk) begin
        legacy_rvalid <= 1'b0;
        if (mem_en) begin
            memcnt++;
            if (mem_we) vmem[int'(mem_addr)] = mem_wdata;
            else mem_rdata <= vmem.exists(int'(mem_addr)) ? vmem[int'(mem_addr)] : 8'h00;
        end
        if (legacy_req) begin
            legcnt++;
            if (!legacy_we) begin
                legacy_rvalid <= 1'b1;
                legacy_rdata  <= legacy_ofs[7:0] ^ 8'h3C;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data as responses appear.
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected rvalid", int'(host_rdata), -1);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(host_rdata == e, t, int'(host_rdata), int'(e));
            end
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (host_busy || exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Driver: one request, expected read value pushed to the scoreboard.
    task automatic access(input bit we, input logic [16:0] ofs, input logic [7:0] d,
                          input logic [7:0] exp, input string tag);
        @(negedge clk);
        while (host_busy) @(negedge clk);
        host_req = 1'b1; host_we = we; host_ofs = ofs; host_wdata = d;
        if (!we) begin exp_q.push_back(exp); tag_q.push_back(tag); end
        @(negedge clk);
        host_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        report();
        $finish;
    end

    initial begin
        int m0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!host_busy && !host_rvalid && !mem_en, "R10 reset idle", {host_busy, host_rvalid, mem_en}, 0);

        // R1 legacy forwarding
        m0 = memcnt;
        access(1'b1, 17'h155, 8'h9A, 8'h00, "R1");
        wait_idle();
        chk(legcnt == 1 && memcnt == m0, "R1 legacy write forwarded", legcnt, 1);
        access(1'b0, 17'h042, 8'h00, 8'h42 ^ 8'h3C, "R1 legacy read");
        wait_idle();

        // R3 linear addressing
        pix_mode_en = 3'b001; linear_sel = 1'b1; wr_bank = 4'd3; rd_bank = 4'd3;
        m0 = memcnt;
        access(1'b1, 17'h01234, 8'h5A, 8'h00, "R3");
        wait_idle();
        chk(vmem.exists(32'h31234) && vmem[32'h31234] == 8'h5A, "R3 linear write address",
            vmem.exists(32'h31234) ? int'(vmem[32'h31234]) : -1, 8'h5A);
        chk(memcnt - m0 == 1, "R8 linear single cycle", memcnt - m0, 1);
        access(1'b0, 17'h01234, 8'h00, 8'h5A, "R3 linear read");
        wait_idle();

        // R7 separate banks
        wr_bank = 4'd2;
        access(1'b1, 17'h01234, 8'h77, 8'h00, "R7");
        wait_idle();
        chk(vmem.exists(32'h21234) && vmem[32'h21234] == 8'h77, "R7 write uses write bank",
            vmem.exists(32'h21234) ? int'(vmem[32'h21234]) : -1, 8'h77);
        access(1'b0, 17'h01234, 8'h00, 8'h5A, "R7 read uses read bank");
        wait_idle();

        // R2 offset bit 16
        vmem[32'h30000] = 8'h99;
        m0 = memcnt;
        access(1'b1, 17'h11234, 8'hEE, 8'h00, "R2");
        wait_idle();
        chk(memcnt == m0 && vmem[32'h21234] == 8'h77, "R2 write dropped", memcnt - m0, 0);
        access(1'b0, 17'h10000, 8'h00, 8'h00, "R2 read returns zero");
        wait_idle();

        // R4/R5 planar write, mask 1010
        pix_mode_en = 3'b010; linear_sel = 1'b0; wr_bank = 4'd1; plane_mask = 4'b1010;
        vmem[32'h10040] = 8'h11; vmem[32'h10041] = 8'h22;
        vmem[32'h10042] = 8'h33; vmem[32'h10043] = 8'h44;
        m0 = memcnt;
        access(1'b1, 17'h00010, 8'hC3, 8'h00, "R5");
        wait_idle();
        chk(vmem[32'h10041] == 8'hC3 && vmem[32'h10043] == 8'hC3, "R4 planar enabled addresses",
            {vmem[32'h10041], vmem[32'h10043]}, 16'hC3C3);
        chk(vmem[32'h10040] == 8'h11 && vmem[32'h10042] == 8'h33, "R5 masked planes untouched",
            {vmem[32'h10040], vmem[32'h10042]}, 16'h1133);
        chk(memcnt - m0 == 2, "R8 two planes two cycles", memcnt - m0, 2);

        // R6 planar read OR
        rd_bank = 4'd5; plane_mask = 4'b1101;
        vmem[32'h50080] = 8'h01; vmem[32'h50081] = 8'h02;
        vmem[32'h50082] = 8'h04; vmem[32'h50083] = 8'h80;
        m0 = memcnt;
        access(1'b0, 17'h00020, 8'h00, 8'h85, "R6 OR of planes 0,2,3");
        wait_idle();
        chk(memcnt - m0 == 3, "R8 three planes three cycles", memcnt - m0, 3);
        plane_mask = 4'b1111;
        access(1'b0, 17'h00020, 8'h00, 8'h87, "R6 OR of all planes");
        chk(host_busy == 1'b1, "R8 busy while planes issue", int'(host_busy), 1);
        wait_idle();

        // R11 empty mask
        plane_mask = 4'b0000;
        m0 = memcnt;
        access(1'b0, 17'h00020, 8'h00, 8'h00, "R11 empty mask read");
        access(1'b1, 17'h00020, 8'hFF, 8'h00, "R11");
        wait_idle();
        chk(memcnt == m0 && vmem[32'h50080] == 8'h01, "R11 no memory cycle", memcnt - m0, 0);

        // R9 wrap modulo 2^20
        pix_mode_en = 3'b100; wr_bank = 4'd15; rd_bank = 4'd15; plane_mask = 4'b1000;
        access(1'b1, 17'h0FFFF, 8'h3E, 8'h00, "R9");
        wait_idle();
        chk(vmem.exists(32'h2FFFF) && vmem[32'h2FFFF] == 8'h3E, "R9 planar address wraps",
            vmem.exists(32'h2FFFF) ? int'(vmem[32'h2FFFF]) : -1, 8'h3E);
        access(1'b0, 17'h0FFFF, 8'h00, 8'h3E, "R9 wrapped read");
        wait_idle();

        report();
        $finish;
    end
endmodule